// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the control core behind a serial flash slave that writes the array two bytes at a time while the address advances on its own. A serial front end delivers the received bytes of each chip-select frame, plus a strobe when chip select falls, a strobe when it rises, and the chip-select level. The first word command of a session carries an opcode, a three-byte address and two data bytes. Every later word command carries only the opcode and two data bytes, and those bytes land at the next word address. For each word the sequencer issues two single-byte program requests to the array interface. It then holds a busy flag for a parameterised number of cycles, which stands in for the internal program time.

The write-enable latch and the address protection decode sit outside the block. The block shows the address it wants judged on `chk_addr` and reads the verdict back on `prot_hit`. While a session is open, only a few opcodes are legal, and `block_cmd` tells the rest of the slave to drop any other opcode. An optional hardware-detect mode turns the serial data output into a live ready line whenever chip select is asserted during a session.

Top module: `aai_word_seq`

## Requirements
- R1: After reset, `aai_flag`, `busy`, `prog_req`, `wel_clr`, `hw_mode` and `so_oe` are all 0.
- R2: A frame of six bytes (opcode 0xAD, three address bytes with the most significant first, data byte D0, data byte D1) starts a session when `wel_in` is 1 and `prot_hit` is 0 at the chip-select rise. On the two cycles after that rise, `prog_req` is 1: first with D0 at the address with bit 0 cleared, then with D1 at the same address with bit 0 set. On the third cycle `prog_req` is 0. `aai_flag` reads 1 from the first of those cycles.
- R3: Inside a session, a three-byte frame (0xAD, D0, D1) programs the word two bytes above the previous word, in the same order as in R2.
- R4: A start frame is ignored, with no program request and `aai_flag` left at 0, if `wel_in` is 0 or `prot_hit` is 1 for the start address shown on `chk_addr`.
- R5: `busy` is 1 for exactly PROG_CYC cycles, starting with the cycle after the chip-select rise that begins a word. A word frame that completes while `busy` is 1 issues no request and does not move the pointer.
- R6: A frame whose byte count at the chip-select rise does not match its opcode (6 for a start, 3 for a later word, 1 for 0x04, 0x70 and 0x80) has no effect.
- R7: A one-byte 0x04 frame inside a session, accepted while not busy, clears `aai_flag` and pulses `wel_clr` for one cycle, both in the cycle after the rise.
- R8: While a session is open, `block_cmd` is 1 once the opcode of the current frame is known, unless that opcode is 0xAD, 0x04 or 0x05. In hardware-detect mode, 0x05 is also blocked.
- R9: A one-byte 0x70 frame outside a session sets `hw_mode`, and 0x80 clears it. Inside a session, neither opcode changes it.
- R10: With `hw_mode` set and a session open, `so_oe` follows `cs_active` combinationally, and `so_val` is 0 while busy and 1 when ready. With chip select inactive, `so_oe` is 0.
- R11: When a word's program time ends and the next word address is protected or lies beyond the top of the ADDR_W-bit space, the session closes: `aai_flag` drops and `wel_clr` pulses at the same edge at which `busy` falls. The address never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_fall | input | 1 | Strobe: chip select became active, new frame |
| cs_rise | input | 1 | Strobe: chip select released, frame complete |
| cs_active | input | 1 | Chip select level, 1 while selected |
| rx_valid | input | 1 | One received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte, first byte of a frame is the opcode |
| wel_in | input | 1 | Write-enable latch state |
| prot_hit | input | 1 | Protection verdict for `chk_addr` |
| chk_addr | output | ADDR_W | Address to be judged: frame address outside a session, next word inside |
| prog_req | output | 1 | Single-byte program request |
| prog_addr | output | ADDR_W | Byte address of the request |
| prog_data | output | 8 | Byte to program |
| busy | output | 1 | Internal program time running |
| aai_flag | output | 1 | Auto-increment session open |
| wel_clr | output | 1 | One-cycle pulse to clear the write-enable latch |
| block_cmd | output | 1 | Current frame opcode is not legal in the session |
| hw_mode | output | 1 | Hardware ready-line mode enabled |
| so_oe | output | 1 | Drive enable for the serial output |
| so_val | output | 1 | Ready-line value, 1 ready and 0 busy |

## Verification
A pointer that advances wrongly shows up on `prog_addr` at the next accepted word. That is at most PROG_CYC plus a frame's length later, so the bench follows several words in a row and also one word that arrives during the busy time. A stale session flag shows up on `block_cmd` and `so_oe` the moment the next frame opens, and on the missing or extra `wel_clr` pulse at the edge where `busy` falls. A busy counter with the wrong length is seen as a busy window that is too short or too long, and the bench counts that window cycle by cycle.

// File: rtl/aai_pkg.sv
package aai_pkg;
   localparam logic [7:0] OP_WORD  = 8'hAD;
   localparam logic [7:0] OP_WRDIS = 8'h04;
   localparam logic [7:0] OP_STAT  = 8'h05;
   localparam logic [7:0] OP_HWON  = 8'h70;
   localparam logic [7:0] OP_HWOFF = 8'h80;

   localparam logic [2:0] LEN_START = 3'd6;
   localparam logic [2:0] LEN_NEXT  = 3'd3;
   localparam logic [2:0] LEN_ONE   = 3'd1;

   typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} phase_e;

   function automatic logic op_allowed(input logic [7:0] op, input logic hw);
      op_allowed = (op == OP_WORD) || (op == OP_WRDIS) || (!hw && (op == OP_STAT));
   endfunction
endpackage

// File: rtl/aai_frame_cap.sv
module aai_frame_cap #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_fall,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic [7:0]        op,
   output logic              op_seen,
   output logic [2:0]        nbytes,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        d_first,
   output logic [7:0]        d_second
);
   logic [23:0] addr_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op       <= '0;
         op_seen  <= 1'b0;
         nbytes   <= '0;
         addr_sh  <= '0;
         d_first  <= '0;
         d_second <= '0;
      end else if (cs_fall) begin
         op_seen <= 1'b0;
         nbytes  <= '0;
      end else if (rx_valid) begin
         if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
         if (nbytes == 3'd0) begin
            op      <= rx_byte;
            op_seen <= 1'b1;
         end
         if (nbytes >= 3'd1 && nbytes <= 3'd3) addr_sh <= {addr_sh[15:0], rx_byte};
         d_first  <= d_second;
         d_second <= rx_byte;
      end
   end

   assign addr = addr_sh[ADDR_W-1:0];
endmodule

// File: rtl/aai_busy_timer.sv
module aai_busy_timer #(
   parameter int PROG_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(PROG_CYC + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (start)         cnt <= CW'(PROG_CYC);
      else if (cnt != '0)     cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));
endmodule

// File: rtl/aai_ready_line.sv
module aai_ready_line #(
   parameter bit HW_DETECT_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_hw,
   input  logic clr_hw,
   input  logic session,
   input  logic busy,
   input  logic cs_active,
   output logic hw_mode,
   output logic so_oe,
   output logic so_val
);
   generate
      if (HW_DETECT_EN) begin : g_line
         logic mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      mode_q <= 1'b0;
            else if (set_hw) mode_q <= 1'b1;
            else if (clr_hw) mode_q <= 1'b0;
         end
         assign hw_mode = mode_q;
         assign so_oe   = mode_q && (session || busy) && cs_active;
         assign so_val  = !busy;
      end else begin : g_none
         assign hw_mode = 1'b0;
         assign so_oe   = 1'b0;
         assign so_val  = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq #(
   parameter int ADDR_W       = 20,
   parameter int PROG_CYC     = 8,
   parameter bit HW_DETECT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              cs_active,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              wel_in,
   input  logic              prot_hit,
   output logic [ADDR_W-1:0] chk_addr,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data,
   output logic              busy,
   output logic              aai_flag,
   output logic              wel_clr,
   output logic              block_cmd,
   output logic              hw_mode,
   output logic              so_oe,
   output logic              so_val
);
   import aai_pkg::*;

   localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(2);

   if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_aw
      $error("ADDR_W must lie in 2..24");
   end
   if (PROG_CYC < 2) begin : g_bad_pc
      $error("PROG_CYC must be at least 2");
   end

   logic [7:0]        f_op;
   logic              f_seen;
   logic [2:0]        f_n;
   logic [ADDR_W-1:0] f_addr;
   logic [7:0]        f_d0, f_d1;

   aai_frame_cap #(.ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .op(f_op), .op_seen(f_seen), .nbytes(f_n),
      .addr(f_addr), .d_first(f_d0), .d_second(f_d1)
   );

   logic exec, start_go, next_go, wrdi_go, hw_on, hw_off, load, t_done, end_now;

   assign exec     = cs_rise && f_seen;
   assign start_go = exec && !aai_flag && (f_op == OP_WORD) && (f_n == LEN_START)
                     && wel_in && !prot_hit;
   assign next_go  = exec && aai_flag && !busy && (f_op == OP_WORD) && (f_n == LEN_NEXT);
   assign wrdi_go  = exec && aai_flag && !busy && (f_op == OP_WRDIS) && (f_n == LEN_ONE);
   assign hw_on    = exec && !aai_flag && (f_op == OP_HWON)  && (f_n == LEN_ONE);
   assign hw_off   = exec && !aai_flag && (f_op == OP_HWOFF) && (f_n == LEN_ONE);
   assign load     = start_go || next_go;

   aai_busy_timer #(.PROG_CYC(PROG_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(load), .busy(busy), .done(t_done)
   );

   logic [ADDR_W:0]   ptr;
   logic [ADDR_W-1:0] word_a;
   logic [7:0]        d_lo, d_hi;
   phase_e            phase;

   assign end_now = t_done && (ptr[ADDR_W] || prot_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aai_flag <= 1'b0;
         wel_clr  <= 1'b0;
         ptr      <= '0;
         word_a   <= '0;
         d_lo     <= '0;
         d_hi     <= '0;
         phase    <= PH_IDLE;
      end else begin
         wel_clr <= wrdi_go || end_now;
         if (start_go)                aai_flag <= 1'b1;
         else if (wrdi_go || end_now) aai_flag <= 1'b0;

         if (start_go) begin
            word_a <= {f_addr[ADDR_W-1:1], 1'b0};
            ptr    <= {1'b0, f_addr[ADDR_W-1:1], 1'b0} + STEP;
         end else if (next_go) begin
            word_a <= ptr[ADDR_W-1:0];
            ptr    <= ptr + STEP;
         end
         if (load) begin
            d_lo <= f_d0;
            d_hi <= f_d1;
         end

         case (phase)
            PH_LO:   phase <= PH_HI;
            PH_HI:   phase <= PH_IDLE;
            default: phase <= load ? PH_LO : PH_IDLE;
         endcase
      end
   end

   assign prog_req  = (phase != PH_IDLE);
   assign prog_addr = {word_a[ADDR_W-1:1], phase == PH_HI};
   assign prog_data = (phase == PH_HI) ? d_hi : d_lo;
   assign chk_addr  = aai_flag ? ptr[ADDR_W-1:0] : f_addr;
   assign block_cmd = aai_flag && f_seen && !op_allowed(f_op, hw_mode);

   aai_ready_line #(.HW_DETECT_EN(HW_DETECT_EN)) u_rdy (
      .clk(clk), .rst_n(rst_n), .set_hw(hw_on), .clr_hw(hw_off),
      .session(aai_flag), .busy(busy), .cs_active(cs_active),
      .hw_mode(hw_mode), .so_oe(so_oe), .so_val(so_val)
   );
endmodule

// File: rtl/aai_word_seq_chk.sv
module aai_word_seq_chk #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_rise,
   input logic              cs_active,
   input logic              wel_in,
   input logic              prog_req,
   input logic [ADDR_W-1:0] prog_addr,
   input logic              busy,
   input logic              aai_flag,
   input logic              wel_clr,
   input logic              so_oe
);
   p_even_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_req) |-> !prog_addr[0]);

   p_pair_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_req) |=> prog_req && prog_addr[0]
                          && prog_addr[ADDR_W-1:1] == $past(prog_addr[ADDR_W-1:1]));

   p_req_inside_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> busy);

   p_busy_in_session_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> aai_flag);

   p_no_start_without_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise && !aai_flag && !wel_in |=> !aai_flag);

   p_session_end_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clr |-> !aai_flag);

   p_so_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active |-> !so_oe);
endmodule

bind aai_word_seq aai_word_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_active(cs_active),
   .wel_in(wel_in), .prog_req(prog_req), .prog_addr(prog_addr), .busy(busy),
   .aai_flag(aai_flag), .wel_clr(wel_clr), .so_oe(so_oe)
);

// File: tb/tb_aai_word_seq.sv
module tb_aai_word_seq;
   localparam int AW = 20;
   localparam int PC = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_fall = 0, cs_rise = 0, cs_active = 0, rx_valid = 0;
   logic [7:0] rx_byte = '0;
   logic wel_in = 1'b0;
   logic prot_hit;
   logic [AW-1:0] chk_addr, prog_addr;
   logic [7:0] prog_data;
   logic prog_req, busy, aai_flag, wel_clr, block_cmd, hw_mode, so_oe, so_val;
   logic [AW:0] prot_base = 21'h100000;

   int errors = 0;
   int checks = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   assign prot_hit = ({1'b0, chk_addr} >= prot_base);

   aai_word_seq #(.ADDR_W(AW), .PROG_CYC(PC), .HW_DETECT_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .cs_active(cs_active), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .wel_in(wel_in), .prot_hit(prot_hit), .chk_addr(chk_addr),
      .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
      .busy(busy), .aai_flag(aai_flag), .wel_clr(wel_clr), .block_cmd(block_cmd),
      .hw_mode(hw_mode), .so_oe(so_oe), .so_val(so_val)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic open_frame(input logic [7:0] op);
      cs_fall = 1; cs_active = 1; tick(); cs_fall = 0;
      rx_valid = 1; rx_byte = op; tick(); rx_valid = 0;
   endtask

   task automatic push(input logic [7:0] b);
      rx_valid = 1; rx_byte = b; tick(); rx_valid = 0;
   endtask

   task automatic close_frame();
      cs_rise = 1; cs_active = 0; tick(); cs_rise = 0;
   endtask

   task automatic send_start(input logic [23:0] a, input logic [7:0] d0, input logic [7:0] d1);
      open_frame(8'hAD); push(a[23:16]); push(a[15:8]); push(a[7:0]);
      push(d0); push(d1); close_frame();
   endtask

   task automatic send_next(input logic [7:0] d0, input logic [7:0] d1);
      open_frame(8'hAD); push(d0); push(d1); close_frame();
   endtask

   task automatic send_one(input logic [7:0] op);
      open_frame(op); close_frame();
   endtask

   // Called right after the closing edge; consumes two more edges.
   task automatic check_pair(input string tag, input int a, input logic [7:0] d0, input logic [7:0] d1);
      chk({tag, " req lo"}, prog_req, 1);
      chk({tag, " addr lo"}, prog_addr, a & ~1);
      chk({tag, " data lo"}, prog_data, d0);
      tick();
      chk({tag, " req hi"}, prog_req, 1);
      chk({tag, " addr hi"}, prog_addr, a | 1);
      chk({tag, " data hi"}, prog_data, d1);
      tick();
      chk({tag, " req end"}, prog_req, 0);
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin n++; tick(); end
   endtask

   task automatic t_reset();
      chk("R1 aai_flag", aai_flag, 0);
      chk("R1 busy", busy, 0);
      chk("R1 prog_req", prog_req, 0);
      chk("R1 wel_clr", wel_clr, 0);
      chk("R1 hw_mode", hw_mode, 0);
      chk("R1 so_oe", so_oe, 0);
   endtask

   task automatic t_refused();
      wel_in = 0;
      send_start(24'h000200, 8'h11, 8'h22);
      chk("R4 no wel req", prog_req, 0);
      chk("R4 no wel aai", aai_flag, 0);
      wel_in = 1;
      prot_base = 21'h000100;
      send_start(24'h000200, 8'h11, 8'h22);
      chk("R4 protected req", prog_req, 0);
      chk("R4 protected aai", aai_flag, 0);
      prot_base = 21'h100000;
      open_frame(8'hAD); push(8'h00); push(8'h02); push(8'h00); push(8'h33);
      close_frame();
      chk("R6 short start req", prog_req, 0);
      chk("R6 short start aai", aai_flag, 0);
   endtask

   task automatic t_soft_session();
      int n;
      send_start(24'h000123, 8'hA1, 8'hB2);
      chk("R2 aai set", aai_flag, 1);
      chk("R5 busy first", busy, 1);
      check_pair("R2 first word", 'h122, 8'hA1, 8'hB2);
      wait_idle(n);
      chk("R5 busy length", n + 2, PC);
      chk("R11 session stays", aai_flag, 1);
      send_next(8'h5A, 8'h6B);
      check_pair("R3 second word", 'h124, 8'h5A, 8'h6B);
      send_next(8'h77, 8'h88);
      chk("R5 ignored while busy", prog_req, 0);
      tick();
      chk("R5 ignored while busy next", prog_req, 0);
      wait_idle(n);
      open_frame(8'hAD); push(8'h01); push(8'h02); push(8'h03); push(8'h04); push(8'h05);
      close_frame();
      chk("R6 long frame in session", prog_req, 0);
      send_next(8'h99, 8'hAA);
      check_pair("R3 third word", 'h126, 8'h99, 8'hAA);
      wait_idle(n);
      open_frame(8'h05);
      chk("R8 status legal soft", block_cmd, 0);
      close_frame();
      open_frame(8'h06);
      chk("R8 other opcode blocked", block_cmd, 1);
      close_frame();
      send_one(8'h70);
      open_frame(8'h05);
      chk("R9 0x70 in session no effect", hw_mode, 0);
      chk("R10 no line in soft mode", so_oe, 0);
      close_frame();
      send_one(8'h04);
      chk("R7 wrdis clears aai", aai_flag, 0);
      chk("R7 wel_clr pulse", wel_clr, 1);
      tick();
      chk("R7 wel_clr one cycle", wel_clr, 0);
   endtask

   task automatic t_hw_session();
      int n;
      send_one(8'h70);
      chk("R9 0x70 sets hw mode", hw_mode, 1);
      send_start(24'h000400, 8'hC3, 8'hD4);
      check_pair("R2 hw word", 'h400, 8'hC3, 8'hD4);
      open_frame(8'h05);
      chk("R10 line driven busy oe", so_oe, 1);
      chk("R10 line shows busy", so_val, 0);
      chk("R8 status blocked in hw mode", block_cmd, 1);
      cs_active = 0; #1;
      chk("R10 line released", so_oe, 0);
      cs_rise = 1; tick(); cs_rise = 0;
      wait_idle(n);
      open_frame(8'hAD);
      chk("R10 line ready oe", so_oe, 1);
      chk("R10 line shows ready", so_val, 1);
      chk("R8 word legal hw", block_cmd, 0);
      close_frame();
      send_one(8'h04);
      chk("R7 hw wrdis", aai_flag, 0);
      send_one(8'h80);
      chk("R9 0x80 clears hw mode", hw_mode, 0);
   endtask

   task automatic t_auto_end();
      int n;
      prot_base = 21'h000100;
      send_start(24'h0000FC, 8'h01, 8'h02);
      check_pair("R11 word FC", 'hFC, 8'h01, 8'h02);
      wait_idle(n);
      chk("R11 not yet ended", aai_flag, 1);
      send_next(8'h03, 8'h04);
      check_pair("R11 word FE", 'hFE, 8'h03, 8'h04);
      wait_idle(n);
      chk("R11 protected end aai", aai_flag, 0);
      chk("R11 protected end wel_clr", wel_clr, 1);
      prot_base = 21'h100000;
      send_start(24'h0FFFFE, 8'h55, 8'h66);
      check_pair("R11 top word", 'hFFFFE, 8'h55, 8'h66);
      wait_idle(n);
      chk("R11 top end aai", aai_flag, 0);
      chk("R11 top end wel_clr", wel_clr, 1);
      send_next(8'h12, 8'h34);
      chk("R11 no wrap", prog_req, 0);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1;
      tick();
      t_reset();
      t_refused();
      t_soft_session();
      t_hw_session();
      t_auto_end();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end
endmodule